// File: doc/BRIEF.md
# Segmented DAC Input Encoder

This block is the digital front end of an 8-bit segmented digital-to-analog converter. An 8-bit sample word first passes a complement stage, which inverts every bit when the invert control is high and leaves the word unchanged when it is low. The three top bits of the result become a seven-line thermometer (bar-graph) code that steers equal-weight segments of the ladder. The five low bits stay in binary and steer the binary-weighted part.

The twelve resulting switch controls go through a level-sensitive latch with an active-low enable. While the enable is low the latch is open and the switch controls follow the data with no clock. When the enable rises, the latch captures the word and holds it for as long as the enable stays high. A system that wants low glitch energy pulses the enable. A system that wants unclocked conversion ties it low. An active-low asynchronous reset forces the switch controls to the all-zero code.

Top module: `dac_seg_encoder`

## Requirements
- R1: With `cmpl_i` high, all eight data bits are inverted before encoding. With `cmpl_i` low, they pass unchanged. The result is called the processed word P.
- R2: Thermometer line k (k = 0..6) is carried on `code_o[5+k]`. It is high exactly when k is less than the value of P[7:5]. A value of 0 gives all seven lines low and a value of 7 gives all seven lines high.
- R3: `code_o[4:0]` equals P[4:0] in plain binary, with bit i carrying weight 2^i.
- R4: The modelled analog level, (number of high lines in `code_o[11:5]`) × 32 + `code_o[4:0]`, equals P for all 256 data codes at both levels of `cmpl_i`.
- R5: While `le_n_i` is low and reset is inactive, `code_o` follows the data and the invert control combinationally, with no clock.
- R6: On a rising edge of `le_n_i`, the latch captures the encoded word. While `le_n_i` stays high, later changes of `data_i` or `cmpl_i` have no effect on `code_o`.
- R7: While `rst_n_i` is low, `code_o` is all zero whatever the state of `le_n_i`. If reset is released while `le_n_i` is high, `code_o` stays zero until `le_n_i` goes low.
- R8: The high thermometer lines always form one unbroken run that starts at line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 8 | Sample word; bit 0 has weight 1 and bit 7 has weight 128, high means one |
| cmpl_i | input | 1 | Invert control; high inverts all data bits |
| le_n_i | input | 1 | Latch enable, active low; a rising edge captures the word |
| rst_n_i | input | 1 | Asynchronous reset, active low; clears the latch |
| code_o | output | 12 | Switch controls: [11:5] thermometer lines 6..0, [4:0] binary low bits |

## Verification
A wrong captured word lasts until the enable next goes low, and it shows at once at the ports as a modelled level that differs from the processed word. A broken encoder or a broken complement stage shows within the same transparent phase, because the switch controls track the inputs with no clock in between. A latch that leaks or fails to close shows as soon as the data is disturbed while the enable is high. A line out of place shows as a gap in the thermometer run or as a wrong line count.

// File: rtl/dac_seg_pkg.sv
`timescale 1ns/1ps
package dac_seg_pkg;

    localparam int DATA_W   = 8;
    localparam int SEG_BITS = 3;
    localparam int BIN_W    = DATA_W - SEG_BITS;
    localparam int THERM_W  = (1 << SEG_BITS) - 1;
    localparam int CODE_W   = THERM_W + BIN_W;

    typedef logic [DATA_W-1:0] sample_t;

    typedef struct packed {
        logic [THERM_W-1:0] therm;
        logic [BIN_W-1:0]   bin;
    } seg_code_t;

    // Level the ladder would produce: each segment line is worth 2^BIN_W.
    function automatic sample_t code_level(input seg_code_t c);
        sample_t lvl;
        lvl = sample_t'($countones(c.therm)) << BIN_W;
        lvl = lvl + sample_t'(c.bin);
        return lvl;
    endfunction

    // True when the set lines form one run starting at line 0.
    function automatic logic therm_run_ok(input logic [THERM_W-1:0] t);
        logic seen_low;
        logic ok;
        seen_low = 1'b0;
        ok       = 1'b1;
        for (int k = 0; k < THERM_W; k++) begin
            if (!t[k]) seen_low = 1'b1;
            else if (seen_low) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/dac_cmpl_stage.sv
`timescale 1ns/1ps
module dac_cmpl_stage #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] din_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] dout_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign dout_o[b] = din_i[b] ^ inv_i;
    end
endmodule

// File: rtl/dac_therm_enc.sv
`timescale 1ns/1ps
module dac_therm_enc #(
    parameter int IN_W = 3,
    localparam int LINES = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [LINES-1:0] line_o
);
    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign line_o[k] = (int'(val_i) > k);
    end
endmodule

// File: rtl/dac_code_latch.sv
`timescale 1ns/1ps
module dac_code_latch #(
    parameter int WIDTH = 12
) (
    input  logic             rst_n_i,
    input  logic             en_n_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] store_q;

    always_latch begin
        if (!rst_n_i)
            store_q <= '0;
        else if (!en_n_i)
            store_q <= d_i;
    end

    assign q_o = store_q;
endmodule

// File: rtl/dac_seg_encoder.sv
`timescale 1ns/1ps
module dac_seg_encoder
    import dac_seg_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic              cmpl_i,
    input  logic              le_n_i,
    input  logic              rst_n_i,
    output logic [CODE_W-1:0] code_o
);
    sample_t   proc_w;
    seg_code_t enc_w;
    seg_code_t held_w;

    dac_cmpl_stage #(.WIDTH(DATA_W)) u_cmpl (
        .din_i  (data_i),
        .inv_i  (cmpl_i),
        .dout_o (proc_w)
    );

    dac_therm_enc #(.IN_W(SEG_BITS)) u_therm (
        .val_i  (proc_w[DATA_W-1:BIN_W]),
        .line_o (enc_w.therm)
    );

    assign enc_w.bin = proc_w[BIN_W-1:0];

    dac_code_latch #(.WIDTH(CODE_W)) u_latch (
        .rst_n_i (rst_n_i),
        .en_n_i  (le_n_i),
        .d_i     (enc_w),
        .q_o     (held_w)
    );

    assign code_o = held_w;
endmodule

// File: rtl/dac_seg_encoder_chk.sv
`timescale 1ns/1ps
module dac_seg_encoder_chk
    import dac_seg_pkg::*;
(
    input logic [DATA_W-1:0] data_i,
    input logic              cmpl_i,
    input logic              le_n_i,
    input logic              rst_n_i,
    input logic [CODE_W-1:0] code_o
);
    seg_code_t c_w;
    sample_t   p_w;
    sample_t   cap_q;
    logic      cap_vld_q;

    assign c_w = code_o;
    assign p_w = cmpl_i ? ~data_i : data_i;

    always_ff @(posedge le_n_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cap_q     <= '0;
            cap_vld_q <= 1'b0;
        end else begin
            cap_q     <= p_w;
            cap_vld_q <= 1'b1;
        end
    end

    // R5
    transparent_level_chk: assert property (@(posedge le_n_i) disable iff (!rst_n_i)
        code_level(c_w) == p_w);

    // R2
    line_count_chk: assert property (@(posedge le_n_i) disable iff (!rst_n_i)
        $countones(c_w.therm) == int'(p_w[DATA_W-1:BIN_W]));

    // R3
    low_bits_chk: assert property (@(posedge le_n_i) disable iff (!rst_n_i)
        c_w.bin == p_w[BIN_W-1:0]);

    // R6
    held_word_chk: assert property (@(negedge le_n_i) disable iff (!rst_n_i)
        cap_vld_q |-> (code_level(c_w) == cap_q));

    // R8
    always_comb begin
        therm_run_chk: assert (therm_run_ok(c_w.therm));
    end
endmodule

bind dac_seg_encoder dac_seg_encoder_chk u_chk (
    .data_i  (data_i),
    .cmpl_i  (cmpl_i),
    .le_n_i  (le_n_i),
    .rst_n_i (rst_n_i),
    .code_o  (code_o)
);

// File: tb/dac_seg_encoder_tb.sv
`timescale 1ns/1ps
module dac_seg_encoder_tb;

    logic        clk = 1'b0;
    logic [7:0]  data;
    logic        cmpl;
    logic        le_n;
    logic        rst_n;
    logic [11:0] code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [11:0] exp_code;
        logic [7:0]  exp_lvl;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     chk_ev;

    always #5 clk = ~clk;

    dac_seg_encoder u_dut (
        .data_i  (data),
        .cmpl_i  (cmpl),
        .le_n_i  (le_n),
        .rst_n_i (rst_n),
        .code_o  (code)
    );

    // Expected switch code from the requirement text (R1, R2, R3).
    function automatic logic [11:0] model_code(input logic [7:0] d, input logic c);
        logic [7:0] p;
        logic [6:0] t;
        p = c ? ~d : d;
        for (int k = 0; k < 7; k++) t[k] = (k < int'(p[7:5]));
        return {t, p[4:0]};
    endfunction

    function automatic logic [7:0] model_proc(input logic [7:0] d, input logic c);
        return c ? ~d : d;
    endfunction

    function automatic logic [7:0] level_of(input logic [11:0] c);
        return 8'($countones(c[11:5]) * 32) + 8'(c[4:0]);
    endfunction

    task automatic expect_item(input logic [11:0] e, input logic [7:0] lvl, input string tag);
        sb_item_t it;
        it.exp_code = e;
        it.exp_lvl  = lvl;
        it.tag      = tag;
        sb_q.push_back(it);
        #2;
        -> chk_ev;
        #1;
    endtask

    // Monitor: pops each expected item and compares it with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                total++;
                if (code !== it.exp_code) begin
                    bad++;
                    $display("FAIL %s: code actual=%h expected=%h", it.tag, code, it.exp_code);
                end
                total++;
                if (level_of(code) !== it.exp_lvl) begin
                    bad++;
                    $display("FAIL R4 (%s): level actual=%0d expected=%0d",
                             it.tag, level_of(code), it.exp_lvl);
                end
            end
        end
    end

    task automatic latch_word(input logic [7:0] d, input logic c);
        @(negedge clk);
        data = d; cmpl = c; le_n = 1'b0;
        @(negedge clk);
        le_n = 1'b1;
        @(negedge clk);
        // R6: disturb the inputs after the capture edge
        data = ~d; cmpl = ~c;
        expect_item(model_code(d, c), model_proc(d, c), "R1/R2/R3/R6 clocked");
    endtask

    initial begin
        rst_n = 1'b0; le_n = 1'b1; data = 8'hA5; cmpl = 1'b0;
        repeat (3) @(negedge clk);
        // R7: reset state with latch closed
        expect_item(12'h000, 8'h00, "R7 reset closed");
        le_n = 1'b0; data = 8'hFF;
        @(negedge clk);
        expect_item(12'h000, 8'h00, "R7 reset open");
        le_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        data = 8'h3C; cmpl = 1'b1;
        @(negedge clk);
        expect_item(12'h000, 8'h00, "R7 release closed");

        // R1 R2 R3 R4 R6: full sweep, clocked operation
        for (int c = 0; c < 2; c++) begin
            for (int d = 0; d < 256; d++) begin
                latch_word(8'(d), c[0]);
            end
        end

        // R5: enable tied low, output follows data and invert control
        @(negedge clk);
        le_n = 1'b0;
        for (int c = 0; c < 2; c++) begin
            for (int d = 0; d < 256; d += 17) begin
                @(negedge clk);
                data = 8'(d); cmpl = c[0];
                expect_item(model_code(8'(d), c[0]), model_proc(8'(d), c[0]), "R5 transparent");
            end
        end
        @(negedge clk);
        data = 8'hE0; cmpl = 1'b0;
        expect_item(model_code(8'hE0, 1'b0), 8'hE0, "R5 transparent edge");

        // R7: reset clears a held nonzero word
        latch_word(8'hFF, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        expect_item(12'h000, 8'h00, "R7 clear held");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_item(12'h000, 8'h00, "R7 stays zero");
        latch_word(8'h61, 1'b1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule